// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Conditional Select

This block is a single-cycle integer execution unit for a scalar core. It adds, subtracts, ANDs or inverts two operands at either 32-bit or 64-bit width. It can also choose between the two operands, or between operand A and operand B plus one, according to a 4-bit condition code. The result is combinational. A 4-bit flag register holds negative, zero, carry and overflow. The register is written at the clock edge only when the operation asks for it.

Compare and test are flag-only variants of subtract and AND. Their arithmetic result never reaches the result port. A condition is always judged against the flags already held in the register, so a flag-setting operation in one cycle steers a select in the next cycle. In 32-bit mode only the low half of each operand takes part, and the upper half of the result reads zero.

Top module: `flagsel_alu`

## Requirements
- R1: Opcode encoding is 0=ADD (A+B), 1=SUB (A-B), 2=AND (A&B), 3=MVN (~B), 4=SEL, 5=SELINC, 6=CMP, 7=TST. With wide=1 the four data operations act on all 64 bits, and the result port shows the value in the same cycle.
- R2: With wide=0 only bits [31:0] of the operands are used, the 32-bit operation is performed, and result[63:32] is zero.
- R3: The flag register is written only for ADD, SUB, AND or MVN with set_flags=1, and always for CMP and TST. In every other case, including SEL and SELINC with set_flags=1, it keeps its value.
- R4: On a write, N takes the top bit of the active-width result (bit 31 or bit 63), and Z is 1 exactly when the active-width result is zero.
- R5: For ADD, C is the carry out of the active width. For SUB, C is 1 when no borrow occurs (A >= B unsigned). V marks signed overflow of the active width. AND and MVN clear C and V.
- R6: CMP writes the flags of SUB and TST writes the flags of AND, while the result port reads zero.
- R7: The condition code is judged against the stored flags as follows: 0 EQ Z, 1 NE !Z, 2 CS C, 3 CC !C, 4 MI N, 5 PL !N, 6 VS V, 7 VC !V, 8 HI C&!Z, 9 LS !C|Z, 10 GE N==V, 11 LT N!=V, 12 GT !Z&(N==V), 13 LE Z|(N!=V), 14 and 15 always true.
- R8: SEL returns A when the condition holds and B otherwise, at the active width.
- R9: SELINC returns A when the condition holds and B+1 otherwise, wrapping at the active width.
- R10: The flags port is {N,Z,C,V}. A write appears on it after the clock edge that samples the operation, and a synchronous active-low reset clears it to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| opcode | input | 3 | Operation select (encoding in R1) |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| set_flags | input | 1 | Request a flag write for ADD/SUB/AND/MVN |
| cond | input | 4 | Condition code for SEL/SELINC (encoding in R7) |
| result | output | 64 | Combinational result |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions assume that operands, opcode, width and set_flags are steady around each rising edge. The stimulus meets this by driving every input on the falling edge. The equal-operand zero check assumes that the equality is judged at the active width, so the stimulus includes operand pairs that match only in their low half. The sweeps take operands from a small set of boundary values: zero, one, all ones, and the sign-bit edges of both widths. Under these operands every flag and every condition code takes both of its values.

// File: rtl/flagsel_pkg.sv
`timescale 1ns/1ps
// Shared types for the flag-setting ALU.
// Assumes a 3-bit opcode and a 4-bit condition code.
package flagsel_pkg;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_AND    = 3'd2,
        OP_MVN    = 3'd3,
        OP_SEL    = 3'd4,
        OP_SELINC = 3'd5,
        OP_CMP    = 3'd6,
        OP_TST    = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/flagsel_cond.sv
`timescale 1ns/1ps
// Condition evaluator: decides whether a 4-bit condition code holds
// for the stored flag set. Purely combinational.
// Assumes the flags come from the registered flag set, not the current op.
module flagsel_cond
    import flagsel_pkg::*;
(
    input  cond_e  cond,
    input  flags_t fl,
    output logic   holds
);

    // Truth of each condition code from the stored flags.
    always_comb begin
        unique case (cond)
            CC_EQ:   holds = fl.z;
            CC_NE:   holds = !fl.z;
            CC_CS:   holds = fl.c;
            CC_CC:   holds = !fl.c;
            CC_MI:   holds = fl.n;
            CC_PL:   holds = !fl.n;
            CC_VS:   holds = fl.v;
            CC_VC:   holds = !fl.v;
            CC_HI:   holds = fl.c && !fl.z;
            CC_LS:   holds = !fl.c || fl.z;
            CC_GE:   holds = (fl.n == fl.v);
            CC_LT:   holds = (fl.n != fl.v);
            CC_GT:   holds = !fl.z && (fl.n == fl.v);
            CC_LE:   holds = fl.z || (fl.n != fl.v);
            default: holds = 1'b1;
        endcase
    end

endmodule

// File: rtl/flagsel_arith.sv
`timescale 1ns/1ps
// Arithmetic and logic lanes. One lane is built for each supported width
// (narrow and full). Each lane returns a zero-extended result and its own
// N, Z, C and V. The caller selects the lane by width.
// Assumes NARROW_W < DATA_W and that take_a is the evaluated condition.
module flagsel_arith
    import flagsel_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    input  logic              wide,
    input  logic              take_a,
    output logic [DATA_W-1:0] res,
    output flags_t            fl_next
);

    localparam int LANES = 2;

    logic [DATA_W-1:0] lane_res [LANES];
    logic [LANES-1:0]  lane_n, lane_z, lane_c, lane_v;

    logic is_sub, is_arith;

    // Decode whether the adder subtracts and whether C/V are meaningful.
    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_CMP);
        is_arith = (op == OP_ADD) || is_sub;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;

        logic [LW-1:0] a_l, b_l, b_add, b_inc, r_l;
        logic [LW:0]   sum;

        // Lane datapath: adder with optional inversion, logic ops, selects.
        always_comb begin
            a_l   = a[LW-1:0];
            b_l   = b[LW-1:0];
            b_add = is_sub ? ~b_l : b_l;
            sum   = {1'b0, a_l} + {1'b0, b_add} + {{LW{1'b0}}, is_sub};
            b_inc = b_l + {{(LW-1){1'b0}}, 1'b1};
            unique case (op)
                OP_ADD, OP_SUB, OP_CMP: r_l = sum[LW-1:0];
                OP_AND, OP_TST:         r_l = a_l & b_l;
                OP_MVN:                 r_l = ~b_l;
                OP_SEL:                 r_l = take_a ? a_l : b_l;
                default:                r_l = take_a ? a_l : b_inc;
            endcase
        end

        // Lane flags and zero extension to the full width.
        always_comb begin
            lane_res[g] = DATA_W'(r_l);
            lane_n[g]   = r_l[LW-1];
            lane_z[g]   = (r_l == '0);
            lane_c[g]   = is_arith && sum[LW];
            lane_v[g]   = is_arith && (a_l[LW-1] == b_add[LW-1])
                                   && (sum[LW-1] != a_l[LW-1]);
        end
    end

    // Width selection between the narrow lane (0) and the full lane (1).
    always_comb begin
        res        = wide ? lane_res[1] : lane_res[0];
        fl_next.n  = wide ? lane_n[1]   : lane_n[0];
        fl_next.z  = wide ? lane_z[1]   : lane_z[0];
        fl_next.c  = wide ? lane_c[1]   : lane_c[0];
        fl_next.v  = wide ? lane_v[1]   : lane_v[0];
    end

endmodule

// File: rtl/flagsel_flagreg.sv
`timescale 1ns/1ps
// Flag register: holds N/Z/C/V and loads a new set when write is high.
// Synchronous active-low reset to all zeros.
module flagsel_flagreg
    import flagsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   write,
    input  flags_t fl_in,
    output flags_t fl_q
);

    // Load on write, otherwise hold; reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n)     fl_q <= '0;
        else if (write) fl_q <= fl_in;
    end

    // R3: without a write the stored flags do not move.
    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!write && $past(rst_n)) |=> $stable(fl_q));

    // R10: a write shows up after the edge.
    assert_flags_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        write |=> (fl_q == $past(fl_in)));

endmodule

// File: rtl/flagsel_alu.sv
`timescale 1ns/1ps
// Flag-setting integer ALU with conditional select (top level).
// It ties together the condition evaluator, the width lanes and the flag
// register, and it decides when the flags are written. Inputs are assumed
// stable around the rising edge. The result port is combinational.
module flagsel_alu
    import flagsel_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int FLAG_W = 4,
    parameter int OP_W   = 3,
    parameter int COND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OP_W-1:0]   opcode,
    input  logic              wide,
    input  logic              set_flags,
    input  logic [COND_W-1:0] cond,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags
);

    localparam int NARROW_W = DATA_W / 2;

    alu_op_e           op;
    flags_t            fl_q, fl_next;
    logic              cond_ok, flag_we, discard;
    logic [DATA_W-1:0] lane_out;

    // Cast raw inputs to the package enums.
    always_comb begin
        op = alu_op_e'(opcode);
    end

    flagsel_cond u_cond (
        .cond  (cond_e'(cond)),
        .fl    (fl_q),
        .holds (cond_ok)
    );

    flagsel_arith #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_arith (
        .a       (op_a),
        .b       (op_b),
        .op      (op),
        .wide    (wide),
        .take_a  (cond_ok),
        .res     (lane_out),
        .fl_next (fl_next)
    );

    // Decide flag writes; compare and test always write and discard data.
    always_comb begin
        discard = (op == OP_CMP) || (op == OP_TST);
        unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_MVN: flag_we = set_flags;
            OP_CMP, OP_TST:                 flag_we = 1'b1;
            default:                        flag_we = 1'b0;
        endcase
    end

    flagsel_flagreg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .write (flag_we),
        .fl_in (fl_next),
        .fl_q  (fl_q)
    );

    // Drive the ports.
    always_comb begin
        result = discard ? '0 : lane_out;
        flags  = fl_q;
    end

    // R2: narrow operations leave the upper half of the result zero.
    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (result[DATA_W-1:NARROW_W] == '0));

    // R6: flag-only operations show zero on the result port.
    assert_discard_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_CMP) || (opcode == OP_TST)) |-> (result == '0));

    // R8: a select whose condition holds passes operand A.
    assert_sel_pick_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_SEL) && cond_ok && wide) |-> (result == op_a));

    // R4: comparing equal operands leaves Z set.
    assert_equal_sets_z_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_CMP) &&
         (wide ? (op_a == op_b) : (op_a[NARROW_W-1:0] == op_b[NARROW_W-1:0])))
        |=> flags[2]);

endmodule

// File: tb/flagsel_alu_tb.sv
`timescale 1ns/1ps
module flagsel_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [2:0]  opcode = '0;
    logic        wide = 1'b0, set_flags = 1'b0;
    logic [3:0]  cond = '0;
    logic [63:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [3:0] exp_fl = 4'b0000;

    always #4 clk = ~clk;

    flagsel_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .wide(wide), .set_flags(set_flags), .cond(cond),
        .result(result), .flags(flags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            5: return 64'h0000_0000_FFFF_FFFF;
            6: return 64'h0000_0000_8000_0000;
            7: return 64'h0000_0000_7FFF_FFFF;
            8: return 64'h1234_5678_0000_0000;
            default: return 64'hA5A5_0F0F_C3C3_9669;
        endcase
    endfunction

    // R7 reference: condition truth from {N,Z,C,V}.
    function automatic bit cond_ref(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    // Arithmetic reference model for R1, R2, R4, R5, R6, R8, R9.
    function automatic void model(input logic [2:0] op, input logic w, input logic sf,
                                  input logic [63:0] a, input logic [63:0] b,
                                  input logic [3:0] c, input logic [3:0] f,
                                  output logic [63:0] res, output logic [3:0] nf,
                                  output logic we);
        logic [63:0] am, bm, r, lim;
        logic signed [65:0] sa, sb, sr;
        logic [65:0] ua, ub;
        logic cy, ov, neg;
        am  = w ? a : {32'b0, a[31:0]};
        bm  = w ? b : {32'b0, b[31:0]};
        lim = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        sa  = w ? {{2{a[63]}}, a} : {{34{a[31]}}, a[31:0]};
        sb  = w ? {{2{b[63]}}, b} : {{34{b[31]}}, b[31:0]};
        ua  = {2'b0, am};
        ub  = {2'b0, bm};
        cy = 0; ov = 0;
        case (op)
            0, 6: ; default: ;
        endcase
        if (op == 0) begin
            r  = (am + bm) & lim;
            cy = (ua + ub) > {2'b0, lim};
            sr = sa + sb;
        end else if (op == 1 || op == 6) begin
            r  = (am - bm) & lim;
            cy = ua >= ub;
            sr = sa - sb;
        end else begin
            sr = '0;
            if (op == 2 || op == 7) r = am & bm;
            else if (op == 3)       r = ~bm & lim;
            else if (op == 4)       r = cond_ref(c, f) ? am : bm;
            else                    r = cond_ref(c, f) ? am : ((bm + 64'd1) & lim);
        end
        if (op <= 1 || op == 6)
            ov = w ? (sr > 66'sh0_7FFF_FFFF_FFFF_FFFF || sr < -66'sh0_8000_0000_0000_0000)
                   : (sr > 66'sh7FFF_FFFF || sr < -66'sh8000_0000);
        neg = w ? r[63] : r[31];
        nf  = {neg, (r == 64'd0), cy, ov};
        we  = (op <= 3) ? sf : (op >= 6);
        res = (op >= 6) ? 64'd0 : r;
    endfunction

    // Apply one operation: check result in-cycle, flags after the edge.
    task automatic run_op(input logic [2:0] op, input logic w, input logic sf,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [3:0] c, input string tag);
        logic [63:0] er;
        logic [3:0]  ef;
        logic        we;
        @(negedge clk);
        opcode = op; wide = w; set_flags = sf; op_a = a; op_b = b; cond = c;
        #1;
        model(op, w, sf, a, b, c, exp_fl, er, ef, we);
        check({tag, " result"}, result, er);
        @(posedge clk); #1;
        if (we) exp_fl = ef;
        check({tag, " flags R3/R4/R5/R10"}, {60'b0, flags}, {60'b0, exp_fl});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset flags", {60'b0, flags}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R4 R5 R6: flag ops over boundary patterns, both widths.
        for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 6; k++) begin
                logic [2:0] op;
                op = (k < 4) ? 3'(k) : 3'(k + 2);
                for (int i = 0; i < 10; i++) begin
                    for (int j = 0; j < 10; j++) begin
                        logic sf;
                        sf = ((i + j + k) % 3) != 0;
                        run_op(op, w[0], sf, pat(i), pat(j), 4'd0, "R1 R2 R6 data");
                        // R9 SELINC with a rotating condition; R3 select ignores set_flags
                        run_op(3'd5, w[0], 1'b1, pat(j), pat(i), 4'((i * 3 + j) % 16), "R9 selinc");
                    end
                    // R7 R8: every condition against the current stored flags
                    for (int c = 0; c < 16; c++)
                        run_op(3'd4, w[0], 1'b1, 64'hAAAA_AAAA_5555_5555,
                               64'h1111_2222_3333_4444, 4'(c), "R7 R8 select");
                end
            end
        end

        // R10: reset clears a nonzero flag set.
        run_op(3'd1, 1'b1, 1'b1, 64'd0, 64'd1, 4'd0, "R5 borrow");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        exp_fl = 4'b0000;
        check("R10 reset after use", {60'b0, flags}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule